// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous DRAM strobe interface and works out what each row-strobe cycle means. It samples the row strobe, column strobe, write enable, output enable, the multiplexed address bus and the write data on a fast internal clock. From the order in which the strobes change it tells apart these cycle types:

- ordinary reads and writes, including early, late and page-mode column cycles;
- refreshes of a row taken from the address bus;
- refreshes of a row taken from an internal counter, in plain and hidden form;
- entry into a parallel test mode.

The block drives a small behavioural cell array and returns read data with an output enable. It is meant for a memory model or an emulator that has to answer a real DRAM controller.

Each decoded cycle appears as one event on an output stream that carries the cycle kind and the row involved. The strobes cannot be stalled, so the stream has a valid signal and no ready. The consumer must take an event in the cycle it is offered, and the block never holds one back. The internal refresh row counter is visible as a plain status output, and so is the sticky test-mode flag. In test mode, one written bit fills a group of sixteen cells. A read of that group then reports whether all sixteen cells agree.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: When the column strobe is already low in the sample where the row strobe falls and write enable is high, the block reports a counter refresh (kind code 3). The row in the event is the counter value, and the address bus has no effect on it.
- R2: When the row strobe falls with the column strobe high and rises again without any column strobe fall, the block reports an address refresh (kind code 2) of the row that was on the address bus at the fall. The data output enable stays low through the whole cycle.
- R3: When the column strobe and write enable are both low in the sample where the row strobe falls, the block reports a test entry (kind code 5). The event row comes from the refresh counter, and the test-mode flag is set.
- R4: The refresh counter is ADDR_W bits wide and resets to 0. It increments by one on every counter-based refresh (kind codes 3, 4 and 5), changes at no other time, and wraps from its all-ones value to 0.
- R5: In a normal row cycle, a column strobe fall with write enable high reads the nibble at the latched row and the sampled column and reports kind 0. The read data is driven on dq_out, and dq_oe is high while output enable is low. The data stays driven until both strobes are high.
- R6: A column strobe fall with write enable low stores din at the addressed cell and reports kind 1. A write enable fall while the column strobe is held low stores din at the column latched at the strobe fall and reports another kind 1 event.
- R7: In test mode, a write stores din bit 0 into 16 cells: all four data bits of the four columns that share every column address bit except the low two. The low two column bits have no effect on which cells are written.
- R8: In test mode, a read returns all ones on dq_out when the 16 cells of the addressed group hold the same value. It returns all zeros when any of them differs.
- R9: An address refresh or a counter refresh with write enable high clears the test-mode flag. A further test entry leaves the flag set.
- R10: When the column strobe stays low from a read while the row strobe rises and falls again, the block reports a hidden refresh (kind code 4) using the counter row. dq_oe and dq_out keep the read data across the hidden refresh.
- R11: Events are single-cycle pulses on evt_valid with no back-pressure. A late write produces a read event followed by a write event. Kind codes are 0 read, 1 write, 2 address refresh, 3 counter refresh, 4 hidden refresh and 5 test entry.
- R12: After reset, evt_valid, dq_oe and test_mode are low and rfsh_ptr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data |
| dq_oe | output | 1 | Read data drive enable |
| test_mode | output | 1 | Parallel test mode is active |
| rfsh_ptr | output | ADDR_W | Next row for counter-based refresh |
| evt_valid | output | 1 | One-cycle pulse for each decoded event |
| evt_kind | output | 3 | Event kind code |
| evt_row | output | ADDR_W | Row accessed or refreshed |

## Verification
The bench builds the block with its default parameters. These are an 11-bit address and refresh counter, four data bits, and a 16-row by 16-column behavioural array. With an 11-bit counter, a full run of 2048 counter refreshes fits easily in the cycle budget, so the wrap from 2047 to 0 is reached directly. A 4-bit column slice holds four test groups of four columns each. This lets the bench show that a compressed write fills exactly one group and leaves the neighbouring group untouched.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic [2:0] {
    EV_READ       = 3'd0,
    EV_WRITE      = 3'd1,
    EV_ADDR_RFSH  = 3'd2,
    EV_CTR_RFSH   = 3'd3,
    EV_HIDDEN     = 3'd4,
    EV_TEST_ENTRY = 3'd5
  } ev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_RFSH
  } dec_state_e;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int ADDR_W = 11,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic              ras_q,
  output logic              cas_q,
  output logic              we_q,
  output logic              oe_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DQ_W-1:0]   din_q,
  output logic              ras_fall,
  output logic              ras_rise,
  output logic              cas_fall,
  output logic              we_fall
);
  localparam int NEDGE = 3;  // strobes that need edge detection

  logic [3:0]       cur;
  logic [NEDGE-1:0] prv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '1;
      prv    <= '1;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      cur    <= {oe_n, we_n, cas_n, ras_n};
      prv    <= cur[NEDGE-1:0];
      addr_q <= addr;
      din_q  <= din;
    end
  end

  assign ras_q = cur[0];
  assign cas_q = cur[1];
  assign we_q  = cur[2];
  assign oe_q  = cur[3];

  assign ras_fall = prv[0] & ~cur[0];
  assign ras_rise = ~prv[0] & cur[0];
  assign cas_fall = prv[1] & ~cur[1];
  assign we_fall  = prv[2] & ~cur[2];
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ptr + 1'b1;  // natural wrap at all-ones
  end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DQ_W     = 4
) (
  input  logic                clk,
  input  logic                test_mode,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic [COL_BITS-1:0] wr_col,
  input  logic [DQ_W-1:0]     wr_data,
  input  logic [ROW_BITS-1:0] rd_row,
  input  logic [COL_BITS-1:0] rd_col,
  output logic [DQ_W-1:0]     rd_data
);
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int COLS     = 1 << COL_BITS;
  localparam int GRP_BITS = 2;
  localparam int GRP      = 1 << GRP_BITS;
  localparam int CELLS    = GRP * DQ_W;

  logic [DQ_W-1:0]  mem [ROWS][COLS];
  logic [CELLS-1:0] grp_cells;
  logic             agree;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (test_mode) begin
        for (int g = 0; g < GRP; g++)
          mem[wr_row][{wr_col[COL_BITS-1:GRP_BITS], GRP_BITS'(g)}] <= {DQ_W{wr_data[0]}};
      end else begin
        mem[wr_row][wr_col] <= wr_data;
      end
    end
  end

  always_comb begin
    for (int g = 0; g < GRP; g++)
      grp_cells[g*DQ_W +: DQ_W] = mem[rd_row][{rd_col[COL_BITS-1:GRP_BITS], GRP_BITS'(g)}];
    agree   = (&grp_cells) | ~(|grp_cells);
    rd_data = test_mode ? {DQ_W{agree}} : mem[rd_row][rd_col];
  end
endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
  import scd_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DQ_W     = 4,
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_q,
  input  logic                cas_q,
  input  logic                we_q,
  input  logic                oe_q,
  input  logic                ras_fall,
  input  logic                ras_rise,
  input  logic                cas_fall,
  input  logic                we_fall,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [DQ_W-1:0]     din_q,
  input  logic [ADDR_W-1:0]   ptr,
  input  logic [DQ_W-1:0]     rd_data,
  output logic                ptr_step,
  output logic                arr_wr,
  output logic [ROW_BITS-1:0] arr_row,
  output logic [COL_BITS-1:0] arr_wr_col,
  output logic [COL_BITS-1:0] arr_rd_col,
  output logic [DQ_W-1:0]     arr_wr_data,
  output logic                test_mode,
  output logic [DQ_W-1:0]     dout,
  output logic                dq_oe,
  output logic                evt_valid,
  output logic [2:0]          evt_kind,
  output logic [ADDR_W-1:0]   evt_row
);
  dec_state_e          st;
  ev_kind_e            kind_r;
  logic [ADDR_W-1:0]   row_r;
  logic [COL_BITS-1:0] col_r;
  logic                cas_seen;
  logic                hold;
  logic                test_r;
  logic                ctr_rfsh;
  logic                early_wr;
  logic                late_wr;

  // CAS level is taken before the RAS edge in the same sample.
  assign ctr_rfsh = ras_fall & ~cas_q;
  assign early_wr = (st == ST_ROW) & cas_fall & ~we_q;
  assign late_wr  = (st == ST_ROW) & ~cas_fall & ~cas_q & cas_seen & we_fall;

  assign ptr_step    = ctr_rfsh;
  assign arr_wr      = early_wr | late_wr;
  assign arr_row     = row_r[ROW_BITS-1:0];
  assign arr_wr_col  = early_wr ? addr_q[COL_BITS-1:0] : col_r;
  assign arr_rd_col  = addr_q[COL_BITS-1:0];
  assign arr_wr_data = din_q;

  assign test_mode = test_r;
  assign dq_oe     = hold & ~oe_q;
  assign evt_kind  = kind_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind_r    <= EV_READ;
      row_r     <= '0;
      col_r     <= '0;
      cas_seen  <= 1'b0;
      hold      <= 1'b0;
      test_r    <= 1'b0;
      dout      <= '0;
      evt_valid <= 1'b0;
      evt_row   <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (ras_q && cas_q) hold <= 1'b0;

      if (ctr_rfsh) begin
        st        <= ST_RFSH;
        evt_valid <= 1'b1;
        evt_row   <= ptr;
        if (!we_q) begin
          kind_r <= EV_TEST_ENTRY;
          test_r <= 1'b1;
        end else begin
          kind_r <= hold ? EV_HIDDEN : EV_CTR_RFSH;
          test_r <= 1'b0;
        end
      end else if (ras_fall) begin
        st       <= ST_ROW;
        row_r    <= addr_q;
        cas_seen <= 1'b0;
      end else if (ras_rise) begin
        st <= ST_IDLE;
        if (st == ST_ROW && !cas_seen) begin
          evt_valid <= 1'b1;
          kind_r    <= EV_ADDR_RFSH;
          evt_row   <= row_r;
          test_r    <= 1'b0;
        end
      end else if (st == ST_ROW) begin
        if (cas_fall) begin
          cas_seen  <= 1'b1;
          col_r     <= addr_q[COL_BITS-1:0];
          evt_valid <= 1'b1;
          evt_row   <= row_r;
          if (we_q) begin
            kind_r <= EV_READ;
            hold   <= 1'b1;
            dout   <= rd_data;
          end else begin
            kind_r <= EV_WRITE;
            hold   <= 1'b0;
          end
        end else if (late_wr) begin
          evt_valid <= 1'b1;
          evt_row   <= row_r;
          kind_r    <= EV_WRITE;
          hold      <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder #(
  parameter int ADDR_W   = 11,
  parameter int DQ_W     = 4,
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              test_mode,
  output logic [ADDR_W-1:0] rfsh_ptr,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_row
);
  logic                ras_q, cas_q, we_q, oe_q;
  logic                ras_fall, ras_rise, cas_fall, we_fall;
  logic [ADDR_W-1:0]   addr_q;
  logic [DQ_W-1:0]     din_q;
  logic                ptr_step;
  logic                arr_wr;
  logic [ROW_BITS-1:0] arr_row;
  logic [COL_BITS-1:0] arr_wr_col, arr_rd_col;
  logic [DQ_W-1:0]     arr_wr_data, rd_data;

  strobe_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .ras_q(ras_q), .cas_q(cas_q),
    .we_q(we_q), .oe_q(oe_q), .addr_q(addr_q), .din_q(din_q),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .we_fall(we_fall)
  );

  refresh_counter #(.W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(ptr_step), .ptr(rfsh_ptr)
  );

  cycle_fsm #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .ROW_BITS(ROW_BITS),
              .COL_BITS(COL_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q),
    .oe_q(oe_q), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .we_fall(we_fall), .addr_q(addr_q), .din_q(din_q),
    .ptr(rfsh_ptr), .rd_data(rd_data), .ptr_step(ptr_step), .arr_wr(arr_wr),
    .arr_row(arr_row), .arr_wr_col(arr_wr_col), .arr_rd_col(arr_rd_col),
    .arr_wr_data(arr_wr_data), .test_mode(test_mode), .dout(dq_out),
    .dq_oe(dq_oe), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_row(evt_row)
  );

  cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DQ_W(DQ_W)) u_arr (
    .clk(clk), .test_mode(test_mode), .wr_en(arr_wr), .wr_row(arr_row),
    .wr_col(arr_wr_col), .wr_data(arr_wr_data), .rd_row(arr_row),
    .rd_col(arr_rd_col), .rd_data(rd_data)
  );
endmodule

// File: rtl/strobe_cycle_decoder_chk.sv
module strobe_cycle_decoder_chk
  import scd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DQ_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DQ_W-1:0]   dq_out,
  input logic              dq_oe,
  input logic              test_mode,
  input logic [ADDR_W-1:0] rfsh_ptr,
  input logic              evt_valid,
  input logic [2:0]        evt_kind,
  input logic [ADDR_W-1:0] evt_row
);
  logic ctr_evt;
  assign ctr_evt = evt_valid && (evt_kind == EV_CTR_RFSH || evt_kind == EV_HIDDEN ||
                                 evt_kind == EV_TEST_ENTRY);

  AST_TEST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind == EV_TEST_ENTRY |-> test_mode); // R3
  AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && (evt_kind == EV_ADDR_RFSH || evt_kind == EV_CTR_RFSH) |-> !test_mode); // R9
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_evt |-> rfsh_ptr == ADDR_W'(evt_row + 1'b1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_evt |-> $stable(rfsh_ptr)); // R4
  AST_DQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && (evt_kind == EV_ADDR_RFSH || evt_kind == EV_CTR_RFSH ||
                  evt_kind == EV_TEST_ENTRY) |-> !dq_oe); // R2
  AST_HIDDEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind == EV_HIDDEN |-> $stable(dq_out)); // R10
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_kind <= EV_TEST_ENTRY); // R11
endmodule

bind strobe_cycle_decoder strobe_cycle_decoder_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dq_out(dq_out), .dq_oe(dq_oe),
  .test_mode(test_mode), .rfsh_ptr(rfsh_ptr), .evt_valid(evt_valid),
  .evt_kind(evt_kind), .evt_row(evt_row)
);

// File: tb/strobe_cycle_decoder_test.sv
module strobe_cycle_decoder_test;
  localparam int AW = 11;
  localparam int K_RD = 0, K_WR = 1, K_AR = 2, K_CR = 3, K_HID = 4, K_TE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dq_out;
  logic dq_oe, test_mode, evt_valid;
  logic [AW-1:0] rfsh_ptr, evt_row;
  logic [2:0] evt_kind;

  int n_chk = 0;
  int n_fail = 0;
  int mptr = 0;

  typedef struct {
    int    kind;
    int    row;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  strobe_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .test_mode(test_mode), .rfsh_ptr(rfsh_ptr), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_row(evt_row)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int row, input string tag);
    exp_t e;
    e.kind = kind;
    e.row  = row;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: pops the scoreboard whenever the design emits an event (R11)
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected event", int'(evt_kind), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(evt_kind) == e.kind, {e.tag, " kind"}, int'(evt_kind), e.kind);
        chk(int'(evt_row) == e.row, {e.tag, " row"}, int'(evt_row), e.row);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctr_refresh(input bit we_low, input logic [AW-1:0] junk, input string tag);
    addr = junk;
    cas_n = 1'b0;
    we_n = we_low ? 1'b0 : 1'b1;
    cyc(2);
    push(we_low ? K_TE : K_CR, mptr, tag);
    mptr = (mptr + 1) % 2048;
    ras_n = 1'b0;
    cyc(3);
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n = 1'b1;
    cyc(3);
  endtask

  task automatic addr_refresh(input logic [AW-1:0] row, input string tag);
    addr = row;
    push(K_AR, int'(row), tag);
    ras_n = 1'b0;
    cyc(3);
    chk(dq_oe == 1'b0, "R2 dq quiet", int'(dq_oe), 0);
    ras_n = 1'b1;
    cyc(3);
  endtask

  task automatic open_row(input int row);
    addr = AW'(row);
    ras_n = 1'b0;
    cyc(2);
  endtask

  task automatic close_row();
    cas_n = 1'b1;
    we_n = 1'b1;
    cyc(1);
    ras_n = 1'b1;
    cyc(3);
  endtask

  task automatic rd(input int row, input int col, input logic [3:0] exp, input string tag);
    open_row(row);
    push(K_RD, row, tag);
    addr = AW'(col);
    cas_n = 1'b0;
    cyc(3);
    chk(dq_oe == 1'b1, {tag, " oe"}, int'(dq_oe), 1);
    chk(dq_out == exp, {tag, " data"}, int'(dq_out), int'(exp));
    close_row();
  endtask

  task automatic wr_early(input int row, input int col, input logic [3:0] d, input string tag);
    open_row(row);
    push(K_WR, row, tag);
    addr = AW'(col);
    din = d;
    we_n = 1'b0;
    cas_n = 1'b0;
    cyc(3);
    close_row();
  endtask

  task automatic wr_late(input int row, input int col, input logic [3:0] d, input string tag);
    open_row(row);
    push(K_RD, row, tag);
    push(K_WR, row, tag);
    addr = AW'(col);
    cas_n = 1'b0;
    cyc(3);
    din = d;
    we_n = 1'b0;
    cyc(3);
    close_row();
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R12 reset state
    chk(evt_valid == 1'b0, "R12 evt_valid", int'(evt_valid), 0);
    chk(dq_oe == 1'b0, "R12 dq_oe", int'(dq_oe), 0);
    chk(test_mode == 1'b0, "R12 test_mode", int'(test_mode), 0);
    chk(rfsh_ptr == '0, "R12 rfsh_ptr", int'(rfsh_ptr), 0);

    // R5 R6 normal access
    wr_early(2, 3, 4'hA, "R6 early write");
    rd(2, 3, 4'hA, "R5 read back");
    wr_late(2, 4, 4'h5, "R6 late write");
    rd(2, 4, 4'h5, "R5 read late");
    chk(dq_oe == 1'b0, "R5 released", int'(dq_oe), 0);

    // R2 address refresh, counter untouched
    addr_refresh(11'h123, "R2 addr refresh");
    chk(int'(rfsh_ptr) == 0, "R4 ptr after addr refresh", int'(rfsh_ptr), 0);

    // R1 counter refresh ignores address
    ctr_refresh(1'b0, 11'h7AB, "R1 ctr refresh");
    chk(int'(rfsh_ptr) == 1, "R4 ptr step", int'(rfsh_ptr), 1);

    // R3 R7 R8 R9 test mode
    wr_early(1, 0, 4'h0, "R6 prep");
    wr_early(1, 1, 4'hF, "R6 prep");
    wr_early(1, 2, 4'hF, "R6 prep");
    wr_early(1, 3, 4'hF, "R6 prep");
    ctr_refresh(1'b1, 11'h000, "R3 test entry");
    chk(test_mode == 1'b1, "R3 test set", int'(test_mode), 1);
    rd(1, 1, 4'h0, "R8 mismatch");
    wr_early(1, 6, 4'h1, "R7 test write");
    rd(1, 5, 4'hF, "R8 match");
    ctr_refresh(1'b1, 11'h000, "R9 re-entry");
    chk(test_mode == 1'b1, "R9 stays set", int'(test_mode), 1);
    ctr_refresh(1'b0, 11'h000, "R9 cbr exit");
    chk(test_mode == 1'b0, "R9 cleared by cbr", int'(test_mode), 0);
    rd(1, 4, 4'hF, "R7 group col4");
    rd(1, 7, 4'hF, "R7 group col7");
    rd(1, 0, 4'h0, "R7 neighbour kept");
    ctr_refresh(1'b1, 11'h000, "R3 entry again");
    addr_refresh(11'h055, "R9 ras-only exit");
    chk(test_mode == 1'b0, "R9 cleared by ras-only", int'(test_mode), 0);

    // R10 hidden refresh
    open_row(2);
    push(K_RD, 2, "R10 read");
    addr = AW'(3);
    cas_n = 1'b0;
    cyc(3);
    ras_n = 1'b1;
    cyc(3);
    push(K_HID, mptr, "R10 hidden");
    mptr = (mptr + 1) % 2048;
    ras_n = 1'b0;
    cyc(3);
    chk(dq_oe == 1'b1, "R10 oe held", int'(dq_oe), 1);
    chk(dq_out == 4'hA, "R10 data held", int'(dq_out), 10);
    close_row();

    // R4 wrap
    while (mptr != 2047) ctr_refresh(1'b0, 11'h3FF, "R4 walk");
    chk(int'(rfsh_ptr) == 2047, "R4 ptr top", int'(rfsh_ptr), 2047);
    ctr_refresh(1'b0, 11'h3FF, "R4 wrap event");
    chk(int'(rfsh_ptr) == 0, "R4 wrap to zero", int'(rfsh_ptr), 0);

    cyc(4);
    chk(sb.size() == 0, "R11 missing events", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule